// File: doc/BRIEF.md
# Lane-Partitioned Saturating Vector Adder

This block adds two 128-bit operand vectors split into independent integer lanes of 8, 16 or 32 bits. Each operation picks a lane width, chooses between wrap-around and clamping arithmetic, and chooses a signed or unsigned reading of the lanes. A fourth operation, the quad-byte reduction, adds the four signed bytes inside each 32-bit word of the first operand to the matching signed word of the second operand. It clamps the total to the signed 32-bit range.

Results are registered and appear one clock after an operation is issued. A one-bit sticky clamp flag records that at least one lane was clamped since software last wrote it. The flag sits in bit 0 of a 32-bit status word. The status word is read continuously and written through a simple write-enable port. The adder is meant to sit in a vector execution pipeline next to the permute and logic units.

Top module: `simd_sat_adder`

## Requirements
- R1: With `op_code[2]`=0 (wrap mode), each lane's result is the lane sum modulo 2^width. No carry passes from one lane into the next. Lane width is selected by `op_code[1:0]`: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit.
- R2: With `op_code[2]`=1 and `op_code[3]`=0 (unsigned clamp), a lane whose sum exceeds 2^width−1 yields 2^width−1.
- R3: With `op_code[2]`=1 and `op_code[3]`=1 (signed clamp), a lane whose sum exceeds the signed maximum yields that maximum. A lane whose sum falls below the signed minimum yields that minimum. For example, an 8-bit lane clamps to 127 or −128.
- R4: With `op_code[1:0]`=3 (quad-byte reduction, `op_code[3:2]` ignored), result word k is the sum of the four signed bytes of word k of `a_i` and the signed word k of `b_i`. The sum is clamped to −2^31..2^31−1.
- R5: `res_o` takes the new result on the clock edge where `op_valid` is high. It holds its value while `op_valid` is low.
- R6: An issued operation that clamps any lane sets the clamp flag, which is `stat_o[0]`.
- R7: Wrap-mode operations, and clamp-mode operations where no lane clamps, leave the flag unchanged.
- R8: The flag clears only through a status write. A write on a clock edge loads `stat_wdata[0]` into the flag, and it wins over a clamp on that same edge.
- R9: After reset, `res_o` is 0 and `stat_o` is 0. `stat_o[31:1]` always reads 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue an operation this cycle |
| op_code | input | 4 | [1:0] lane size or reduction, [2] clamp, [3] signed |
| a_i | input | 128 | First operand vector |
| b_i | input | 128 | Second operand vector |
| res_o | output | 128 | Registered result vector |
| stat_we | input | 1 | Status write enable |
| stat_wdata | input | 32 | Status write data (bit 0 = clamp flag) |
| stat_o | output | 32 | Status word, bit 0 = sticky clamp flag |

## Verification
The hardest case to reach is the interplay between the sticky flag and the operation stream. The flag must survive wrap-mode and non-clamping operations, and it must lose a same-cycle race against a status write. The bench clears the flag before every table vector, so each vector's clamp outcome is seen in isolation. Directed sequences then set the flag, issue wrap and in-range operations, and finally drive a clamping operation on the same edge as a clearing write. Lane-isolation cases place all-ones operands in adjacent lanes, so a carry leaking across a lane boundary would corrupt the neighbouring lane.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
    localparam int VEC_W  = 128;
    localparam int STAT_W = 32;
    localparam int OP_W   = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_SUM4 = 2'd3
    } lane_sel_e;
endpackage

// File: rtl/simd_lane_bank.sv
module simd_lane_bank #(
    parameter int VW = 128,
    parameter int LW = 8
) (
    input  logic [VW-1:0]       a,
    input  logic [VW-1:0]       b,
    input  logic                sgn,
    input  logic                sat,
    output logic [VW-1:0]       y,
    output logic [VW/LW-1:0]    clamp
);
    localparam int LANES = VW / LW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] la, lb;
        logic [LW:0]   sum_ext;
        logic          ovf;

        assign la      = a[g*LW +: LW];
        assign lb      = b[g*LW +: LW];
        assign sum_ext = {1'b0, la} + {1'b0, lb};
        assign ovf     = sgn ? ((la[LW-1] == lb[LW-1]) && (sum_ext[LW-1] != la[LW-1]))
                             : sum_ext[LW];

        always_comb begin
            clamp[g] = sat && ovf;
            if (sat && ovf) begin
                if (sgn)
                    y[g*LW +: LW] = {la[LW-1], {(LW-1){~la[LW-1]}}};
                else
                    y[g*LW +: LW] = {LW{1'b1}};
            end else begin
                y[g*LW +: LW] = sum_ext[LW-1:0];
            end
        end
    end
endmodule

// File: rtl/simd_sum4.sv
module simd_sum4 #(
    parameter int VW = 128
) (
    input  logic [VW-1:0]     a,
    input  logic [VW-1:0]     b,
    output logic [VW-1:0]     y,
    output logic [VW/32-1:0]  clamp
);
    localparam int WORDS = VW / 32;
    localparam int ACC_W = 34;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [ACC_W-1:0] acc;

        always_comb begin
            acc = {{(ACC_W-32){b[w*32+31]}}, b[w*32 +: 32]};
            for (int k = 0; k < 4; k++) begin
                acc = acc + {{(ACC_W-8){a[w*32+k*8+7]}}, a[w*32+k*8 +: 8]};
            end
            clamp[w] = !((acc[ACC_W-1:31] == '0) || (acc[ACC_W-1:31] == '1));
            if (clamp[w])
                y[w*32 +: 32] = acc[ACC_W-1] ? 32'h8000_0000 : 32'h7FFF_FFFF;
            else
                y[w*32 +: 32] = acc[31:0];
        end
    end
endmodule

// File: rtl/simd_sat_status.sv
module simd_sat_status (
    input  logic clk,
    input  logic rst_n,
    input  logic clamp_evt,
    input  logic we,
    input  logic wbit,
    output logic sat
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            sat <= 1'b0;
        else if (we)
            sat <= wbit;
        else if (clamp_evt)
            sat <= 1'b1;
    end

    // R8
    sat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sat) |-> $past(we));
    // R8
    sat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (sat == $past(wbit)));
    // R6
    sat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_evt && !we) |=> sat);
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
    import simd_add_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int SW = STAT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    input  logic [VW-1:0]   a_i,
    input  logic [VW-1:0]   b_i,
    output logic [VW-1:0]   res_o,
    input  logic            stat_we,
    input  logic [SW-1:0]   stat_wdata,
    output logic [SW-1:0]   stat_o
);
    localparam int N8  = VW / 8;
    localparam int N16 = VW / 16;
    localparam int N32 = VW / 32;

    lane_sel_e       sel;
    logic            sgn, sat_mode;
    logic [VW-1:0]   y8, y16, y32, ysum, y_next;
    logic [N8-1:0]   c8;
    logic [N16-1:0]  c16;
    logic [N32-1:0]  c32, csum;
    logic            any_clamp, sat_q;
    logic [SW-1:0]   unused_wbits;

    assign sel          = lane_sel_e'(op_code[1:0]);
    assign sat_mode     = op_code[2];
    assign sgn          = op_code[3];
    assign unused_wbits = stat_wdata;

    simd_lane_bank #(.VW(VW), .LW(8))  u_b8  (.a(a_i), .b(b_i), .sgn(sgn), .sat(sat_mode), .y(y8),  .clamp(c8));
    simd_lane_bank #(.VW(VW), .LW(16)) u_b16 (.a(a_i), .b(b_i), .sgn(sgn), .sat(sat_mode), .y(y16), .clamp(c16));
    simd_lane_bank #(.VW(VW), .LW(32)) u_b32 (.a(a_i), .b(b_i), .sgn(sgn), .sat(sat_mode), .y(y32), .clamp(c32));
    simd_sum4      #(.VW(VW))          u_sum (.a(a_i), .b(b_i), .y(ysum), .clamp(csum));

    always_comb begin
        unique case (sel)
            SZ_BYTE: begin y_next = y8;   any_clamp = |c8;   end
            SZ_HALF: begin y_next = y16;  any_clamp = |c16;  end
            SZ_WORD: begin y_next = y32;  any_clamp = |c32;  end
            SZ_SUM4: begin y_next = ysum; any_clamp = |csum; end
            default: begin y_next = y8;   any_clamp = 1'b0;  end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            res_o <= '0;
        else if (op_valid)
            res_o <= y_next;
    end

    simd_sat_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .clamp_evt (op_valid && any_clamp),
        .we        (stat_we),
        .wbit      (stat_wdata[0]),
        .sat       (sat_q)
    );

    assign stat_o = {{(SW-1){1'b0}}, sat_q};

    // R5
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(res_o));
    // R7
    wrap_no_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_o[0]) |-> ($past(stat_we) ||
                              ($past(op_valid) && ($past(op_code[2]) || ($past(op_code[1:0]) == 2'd3)))));
endmodule

// File: tb/simd_sat_adder_test.sv
`timescale 1ns/1ps
module simd_sat_adder_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = '0;
    logic [127:0] a_i = '0, b_i = '0;
    logic [127:0] res_o;
    logic         stat_we = 1'b0;
    logic [31:0]  stat_wdata = '0;
    logic [31:0]  stat_o;
    int checks = 0, failures = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    simd_sat_adder uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
                        .a_i(a_i), .b_i(b_i), .res_o(res_o), .stat_we(stat_we),
                        .stat_wdata(stat_wdata), .stat_o(stat_o));

    typedef struct packed {
        logic [3:0]   op;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] y;
        logic         c;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{4'b0000, {16{8'hFF}}, {16{8'h01}}, 128'h0, 1'b0},                        // R1 byte wrap
        '{4'b0100, {16{8'hFF}}, {16{8'h01}}, {16{8'hFF}}, 1'b1},                   // R2 byte max+1
        '{4'b0100, {8{8'hF0, 8'h10}}, {16{8'h20}}, {8{8'hFF, 8'h30}}, 1'b1},       // R2 mixed lanes
        '{4'b1100, {16{8'h7F}}, {16{8'h01}}, {16{8'h7F}}, 1'b1},                   // R3 byte max+1
        '{4'b1100, {16{8'h80}}, {16{8'hFF}}, {16{8'h80}}, 1'b1},                   // R3 byte min-1
        '{4'b1100, {16{8'h7F}}, {16{8'h7F}}, {16{8'h7F}}, 1'b1},                   // R3 byte max+max
        '{4'b1100, {16{8'h05}}, {16{8'hFD}}, {16{8'h02}}, 1'b0},                   // R3 in range
        '{4'b0101, {8{16'hFFFF}}, {8{16'hFFFF}}, {8{16'hFFFF}}, 1'b1},             // R2 half max+max
        '{4'b1101, {8{16'h7FFF}}, {8{16'h0001}}, {8{16'h7FFF}}, 1'b1},             // R3 half max+1
        '{4'b1101, {8{16'h8000}}, {8{16'hFFFF}}, {8{16'h8000}}, 1'b1},             // R3 half min-1
        '{4'b0001, {8{16'h00FF}}, {8{16'h0001}}, {8{16'h0100}}, 1'b0},             // R1 half wrap, carry inside lane
        '{4'b0110, {4{32'hFFFF_FFFF}}, {4{32'h1}}, {4{32'hFFFF_FFFF}}, 1'b1},      // R2 word max+1
        '{4'b1110, {4{32'h8000_0000}}, {4{32'hFFFF_FFFF}}, {4{32'h8000_0000}}, 1'b1}, // R3 word min-1
        '{4'b1110, {4{32'h7FFF_FFFF}}, {4{32'h7FFF_FFFF}}, {4{32'h7FFF_FFFF}}, 1'b1}, // R3 word max+max
        '{4'b0010, {4{32'hFFFF_FFFF}}, {4{32'h1}}, 128'h0, 1'b0},                 // R1 word wrap
        '{4'b1010, {4{32'h7FFF_FFFF}}, {4{32'h1}}, {4{32'h8000_0000}}, 1'b0},      // R1 signed wrap
        '{4'b0011, {4{32'h0102_0304}}, {4{32'd5}}, {4{32'd15}}, 1'b0},            // R4 plain
        '{4'b0011, {4{32'hFFFF_FFFF}}, {4{32'd0}}, {4{32'hFFFF_FFFC}}, 1'b0},     // R4 negative bytes
        '{4'b0011, {16{8'h7F}}, {4{32'h7FFF_FFFF}}, {4{32'h7FFF_FFFF}}, 1'b1},    // R4 clamp high
        '{4'b1111, {16{8'h80}}, {4{32'h8000_0000}}, {4{32'h8000_0000}}, 1'b1}     // R4 clamp low
    };

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; a_i = a; b_i = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic wr_stat(input logic [31:0] d);
        @(negedge clk);
        stat_we = 1'b1; stat_wdata = d;
        @(negedge clk);
        stat_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset result", res_o, 128'h0);
        chk("R9 reset status", {96'h0, stat_o}, 128'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            wr_stat(32'h0);
            issue(TBL[i].op, TBL[i].a, TBL[i].b);
            chk($sformatf("R1-table vec%0d result", i), res_o, TBL[i].y);
            chk($sformatf("R6 R7 vec%0d flag", i), {127'h0, stat_o[0]}, {127'h0, TBL[i].c});
        end

        // R5: hold while op_valid is low
        issue(4'b0000, {16{8'h11}}, {16{8'h22}});
        @(negedge clk);
        a_i = {16{8'h55}}; b_i = {16{8'h66}}; op_code = 4'b0100;
        @(negedge clk);
        chk("R5 hold", res_o, {16{8'h33}});

        // R7/R8: sticky across wrap and in-range clamp ops
        wr_stat(32'h0);
        issue(4'b1100, {16{8'h7F}}, {16{8'h01}});
        chk("R6 set", {127'h0, stat_o[0]}, 128'h1);
        issue(4'b0000, {16{8'hFF}}, {16{8'h01}});
        chk("R7 wrap keeps flag", {127'h0, stat_o[0]}, 128'h1);
        issue(4'b1100, {16{8'h01}}, {16{8'h01}});
        chk("R7 in-range keeps flag", {127'h0, stat_o[0]}, 128'h1);
        chk("R7 in-range result", res_o, {16{8'h02}});

        // R7: wrap overflow leaves clear flag clear
        wr_stat(32'h0);
        issue(4'b1010, {4{32'h7FFF_FFFF}}, {4{32'h7FFF_FFFF}});
        chk("R7 wrap no set", {96'h0, stat_o}, 128'h0);

        // R8: write priority over same-edge clamp
        wr_stat(32'h1);
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'b0100; a_i = {16{8'hFF}}; b_i = {16{8'hFF}};
        stat_we = 1'b1; stat_wdata = 32'h0;
        @(negedge clk);
        op_valid = 1'b0; stat_we = 1'b0;
        chk("R8 write wins", {96'h0, stat_o}, 128'h0);
        chk("R2 same-edge result", res_o, {16{8'hFF}});

        // R9: upper status bits read zero
        wr_stat(32'hFFFF_FFFF);
        chk("R9 upper bits", {96'h0, stat_o}, 128'h1);
        wr_stat(32'hFFFF_FFFE);
        chk("R8 write clears", {96'h0, stat_o}, 128'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R5 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule